// File: doc/BRIEF.md
# Packet Data Whitening Scrambler

This block scrambles a serial bit stream one bit at a time, for the datapath of a packet radio. A 7-stage linear feedback shift register produces a keystream, and each bit that lies in the whitened part of a packet is XORed with that keystream. Bits that the framing logic flags as outside that part, such as preamble and address bits, pass through unchanged. The register holds its state while those bits go by.

XOR with a keystream is its own inverse. The same block therefore whitens on the transmit side and de-whitens on the receive side, as long as both ends load the same seed before the packet. A load strobe copies a seed value into the register. If a load and a data bit arrive in the same cycle, that bit already uses the loaded seed. The output bit and its valid strobe are registered, so they appear one clock after the input.

Top module: `packet_whitener`

## Requirements
- R1: While reset is asserted, and after it is released, `out_vld` and `out_bit` are 0 and the register holds 7'h7F. The first whitened bit after reset uses 7'h7F unless a seed is loaded.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock. While `in_vld` is low, `out_bit` keeps its last value.
- R3: For a valid bit with `wht_en` high, `out_bit` = `in_bit` XOR stage 6 (the MSB of `seed`) of the register state that this bit uses.
- R4: Each advance maps the state s to n, where n[0]=s[6], n[4]=s[3]^s[6], and n[i]=s[i-1] for every other i. This is the polynomial x^7+x^4+1. Starting from a nonzero seed, the keystream repeats with a period of 127.
- R5: For a valid bit with `wht_en` low, `out_bit` = `in_bit`, and the register state does not change.
- R6: `seed_load` high copies `seed` into the register, whether or not `in_vld` is high. A valid bit in the same cycle uses the loaded seed, and the register advances from that seed.
- R7: The register advances exactly once for each valid bit with `wht_en` high. It holds its state on idle cycles.
- R8: Whitening a sequence and then feeding the result back through the block with the same seed returns the original sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| seed | input | 7 | Initial register value; bit 6 is the output stage |
| seed_load | input | 1 | Load `seed` into the register this cycle |
| in_bit | input | 1 | Serial data bit |
| in_vld | input | 1 | `in_bit` is valid this cycle |
| wht_en | input | 1 | The current bit is in the whitened region of the packet |
| out_bit | output | 1 | Scrambled or passed-through bit |
| out_vld | output | 1 | `out_bit` is valid (one cycle after `in_vld`) |

## Verification
The bench sweeps all 128 seeds, including the all-zero seed, which locks the register. Each seed is loaded together with a data bit. The bench then mixes whitened bits, bypassed bits and idle cycles in a pseudo-random pattern and compares every output bit against an arithmetic model of the register. This separates a wrong tap or output stage from a register that advances on bypassed or idle cycles. Separate runs cover the following:
- a load with no data bit;
- a long stretch of bypassed bits;
- a 254-bit keystream that must repeat after 127 bits;
- whiten-then-dewhiten round trips, which must return the input for several seeds.

// File: rtl/whiten_pkg.sv
package whiten_pkg;
  parameter int unsigned WHT_W   = 7;
  parameter int unsigned WHT_TAP = 4;
  typedef logic [WHT_W-1:0] wht_state_t;
  localparam wht_state_t WHT_RST_STATE = '1;
endpackage

// File: rtl/whiten_rst_sync.sv
module whiten_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/whiten_lfsr.sv
module whiten_lfsr
  import whiten_pkg::*;
#(
  parameter int unsigned W       = WHT_W,
  parameter int unsigned TAP     = WHT_TAP,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed_i,
  input  logic         load_i,
  input  logic         adv_i,
  output logic         key_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] base;
  logic [W-1:0] stepped;
  logic [W-1:0] state_d;
  logic         state_en;

  assign base  = load_i ? seed_i : state_q;
  assign key_o = base[W-1];

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stepped[i] = base[W-1];
    end else if (i == TAP) begin : g_tap
      assign stepped[i] = base[i-1] ^ base[W-1];
    end else begin : g_shift
      assign stepped[i] = base[i-1];
    end
  end

  always_comb begin
    state_en = load_i | adv_i;
    state_d  = adv_i ? stepped : base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= RST_VAL;
    else if (state_en) state_q <= state_d;
  end

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R7: the state holds when there is neither a load nor an advance
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (!load_i && !adv_i) |=> $stable(state_q));
  // R6: a load without an advance leaves exactly the seed in the register
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (load_i && !adv_i) |=> (state_q == $past(seed_i)));
  // R4: the head stage takes the old output stage
  a_r4_head: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (adv_i && !load_i) |=> (state_q[0] == $past(state_q[W-1])));
  // R4: the tap stage mixes in the feedback bit
  a_r4_tap: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (adv_i && !load_i) |=> (state_q[TAP] == ($past(state_q[TAP-1]) ^ $past(state_q[W-1]))));
endmodule

// File: rtl/whiten_mixer.sv
module whiten_mixer (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic vld_i,
  input  logic en_i,
  input  logic key_i,
  output logic bit_o,
  output logic vld_o
);
  logic bit_q, bit_d;
  logic vld_q;

  always_comb begin
    bit_d = bit_i ^ (en_i & key_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) bit_q <= bit_d;
    end
  end

  assign bit_o = bit_q;
  assign vld_o = vld_q;

  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2: the output strobe lags the input strobe by one clock
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    vld_o == $past(vld_i));
  // R2: the output bit holds while no bit arrives
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    !vld_i |=> $stable(bit_o));
  // R5: a bypassed bit comes out unchanged
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    (vld_i && !en_i) |=> (bit_o == $past(bit_i)));
  // R1: outputs are quiet in reset
  a_r1_reset: assert property (@(posedge clk) !rst_n |-> (!vld_o && !bit_o));
endmodule

// File: rtl/packet_whitener.sv
module packet_whitener
  import whiten_pkg::*;
#(
  parameter int unsigned W         = WHT_W,
  parameter int unsigned TAP       = WHT_TAP,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] seed,
  input  logic         seed_load,
  input  logic         in_bit,
  input  logic         in_vld,
  input  logic         wht_en,
  output logic         out_bit,
  output logic         out_vld
);
  localparam logic [W-1:0] RST_VAL = '1;

  logic rst_int_n;
  logic advance;
  logic key;

  assign advance = in_vld & wht_en;

  whiten_rst_sync #(.STAGES(SYNC_STGS)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  whiten_lfsr #(.W(W), .TAP(TAP), .RST_VAL(RST_VAL)) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .seed_i (seed),
    .load_i (seed_load),
    .adv_i  (advance),
    .key_o  (key)
  );

  whiten_mixer u_mixer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .bit_i (in_bit),
    .vld_i (in_vld),
    .en_i  (wht_en),
    .key_i (key),
    .bit_o (out_bit),
    .vld_o (out_vld)
  );
endmodule

// File: tb/packet_whitener_tb.sv
module packet_whitener_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] seed;
  logic       seed_load, in_bit, in_vld, wht_en;
  logic       out_bit, out_vld;

  int checks = 0;
  int errors = 0;
  logic [6:0] model_st;
  int unsigned lcg = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  packet_whitener u_dut (
    .clk(clk), .rst_n(rst_n), .seed(seed), .seed_load(seed_load),
    .in_bit(in_bit), .in_vld(in_vld), .wht_en(wht_en),
    .out_bit(out_bit), .out_vld(out_vld)
  );

  function automatic logic [6:0] step(input logic [6:0] s);
    logic [6:0] n;
    n    = {s[5:0], s[6]};
    n[4] = s[3] ^ s[6];
    return n;
  endfunction

  function automatic logic rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[16];
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One valid bit; inputs applied on a falling edge, result sampled on the next
  task automatic xfer(input logic b, input logic en, input logic ld,
                      input logic [6:0] sd, input string tag, output logic got);
    logic [6:0] base;
    logic       exp;
    in_bit = b; wht_en = en; seed_load = ld; seed = sd; in_vld = 1'b1;
    base = ld ? sd : model_st;
    exp  = b ^ (en & base[6]);
    model_st = en ? step(base) : base;
    @(negedge clk);
    got = out_bit;
    chk(out_vld === 1'b1, {tag, " valid"}, out_vld, 1);
    chk(out_bit === exp, tag, out_bit, exp);
    in_vld = 1'b0; seed_load = 1'b0;
  endtask

  task automatic idle(input string tag);
    logic prev;
    prev = out_bit;
    in_vld = 1'b0; seed_load = 1'b0; in_bit = rnd(); wht_en = rnd();
    @(negedge clk);
    chk(out_vld === 1'b0, {tag, " idle valid"}, out_vld, 0);
    chk(out_bit === prev, {tag, " idle hold"}, out_bit, prev);
  endtask

  task automatic load_only(input logic [6:0] sd);
    in_vld = 1'b0; seed_load = 1'b1; seed = sd;
    model_st = sd;
    @(negedge clk);
    chk(out_vld === 1'b0, "R6 load-only valid", out_vld, 0);
    seed_load = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got;
    logic [126:0] ks_a, ks_b;
    logic [31:0]  data, wht;

    rst_n = 1'b0; seed = '0; seed_load = 0; in_bit = 0; in_vld = 0; wht_en = 0;
    model_st = 7'h7F;
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0 && out_bit === 1'b0, "R1 in reset", {out_vld, out_bit}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_vld === 1'b0 && out_bit === 1'b0, "R1 after release", {out_vld, out_bit}, 0);
    // R1: the reset state 7'h7F drives the first whitened bits
    for (int i = 0; i < 10; i++) xfer(1'b0, 1'b1, 1'b0, 7'h00, "R1 reset state", got);

    // R3 R5 R6 R7: sweep every seed, mixing whitened, bypassed and idle cycles
    for (int s = 0; s < 128; s++) begin
      xfer(rnd(), 1'b1, 1'b1, 7'(s), "R6 load with bit", got);
      for (int i = 0; i < 20; i++) begin
        if (rnd() && rnd()) idle("R7");
        else if (rnd()) xfer(rnd(), 1'b1, 1'b0, 7'h00, "R3 whiten", got);
        else            xfer(rnd(), 1'b0, 1'b0, 7'h00, "R5 bypass", got);
      end
    end

    // R6: a load with no data bit
    load_only(7'h2D);
    for (int i = 0; i < 12; i++) xfer(rnd(), 1'b1, 1'b0, 7'h00, "R6 after load-only", got);

    // R5: a long bypass stretch leaves the state untouched
    for (int i = 0; i < 40; i++) xfer(rnd(), 1'b0, 1'b0, 7'h00, "R5 long bypass", got);
    for (int i = 0; i < 8; i++)  xfer(rnd(), 1'b1, 1'b0, 7'h00, "R5 state kept", got);

    // R4: the keystream period is 127
    xfer(1'b0, 1'b1, 1'b1, 7'h01, "R4 period", got);
    ks_a[0] = got;
    for (int i = 1; i < 127; i++) begin xfer(1'b0, 1'b1, 1'b0, 7'h00, "R4 period", got); ks_a[i] = got; end
    for (int i = 0; i < 127; i++) begin xfer(1'b0, 1'b1, 1'b0, 7'h00, "R4 period", got); ks_b[i] = got; end
    chk(ks_a == ks_b, "R4 repeat after 127", $countones(ks_a ^ ks_b), 0);
    chk(ks_a != '0, "R4 nonzero keystream", $countones(ks_a), 64);

    // R8: whiten then de-whiten with the same seed
    for (int s = 0; s < 8; s++) begin
      logic [6:0] sd;
      sd = 7'(s * 37 + 5);
      for (int i = 0; i < 32; i++) data[i] = rnd();
      for (int i = 0; i < 32; i++) begin
        xfer(data[i], 1'b1, (i == 0), sd, "R8 whiten", got);
        wht[i] = got;
      end
      for (int i = 0; i < 32; i++) begin
        xfer(wht[i], 1'b1, (i == 0), sd, "R8 dewhiten", got);
        chk(got === data[i], "R8 round trip", got, data[i]);
      end
    end

    idle("R2 final");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule